// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and calendar date as a chain of packed BCD counters. It holds seconds, minutes and hours in 24-hour form, plus a day-of-week count, the day of the month, the month, a two-digit year and a century. Each field uses two BCD digits in one byte. A one-cycle `sec_tick` pulse, made outside the block once per second, advances the chain by one second. Carries ripple from the seconds field up to the century within that same clock. The day of the month wraps at the length of the current month. February gets a 29th day in every year whose two-digit value is a multiple of four.

A host can preset every field in a single cycle through the parallel set port. A stop input freezes the count while it is asserted. The oscillator, the one-second prescaler, any bus interface and any read buffering sit outside the block.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00 and century 20 (hex-coded BCD; the century value is a parameter).
- R2: Each tick with the stop input low and no set advances seconds by one in BCD. Seconds and minutes wrap 59→00 and carry upward, and hours wrap 23→00 and carry into the date, all in the clock edge that takes the tick.
- R3: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. The month then advances.
- R4: In month 02 the date wraps after 29 when the year is a multiple of four (00, 04, …, 96), and after 28 otherwise.
- R5: The month wraps 12→01 and carries into the year. The year wraps 99→00 and carries into the century, and the century wraps 39→00.
- R6: The weekday counts 01 to 07 and returns to 01. It advances exactly when the date advances.
- R7: While `stop` is high, ticks have no effect and every field keeps its value.
- R8: When `set_en` is high, all eight fields take the set values at the next edge. The set wins over a tick in the same cycle.
- R9: With no tick and no set, every field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| stop | input | 1 | Freezes counting while high |
| set_en | input | 1 | Loads all set fields this cycle |
| set_cen | input | 8 | Century to load (BCD 00-39) |
| set_yr | input | 8 | Year to load (BCD 00-99) |
| set_mon | input | 8 | Month to load (BCD 01-12) |
| set_date | input | 8 | Date to load (BCD 01-31) |
| set_wday | input | 8 | Weekday to load (BCD 01-07) |
| set_hr | input | 8 | Hours to load (BCD 00-23) |
| set_min | input | 8 | Minutes to load (BCD 00-59) |
| set_sec | input | 8 | Seconds to load (BCD 00-59) |
| cen | output | 8 | Century |
| yr | output | 8 | Year |
| mon | output | 8 | Month |
| date | output | 8 | Day of month |
| wday | output | 8 | Day of week |
| hr | output | 8 | Hours |
| min | output | 8 | Minutes |
| sec | output | 8 | Seconds |

## Verification
The assertions check on every cycle that a set lands exactly and that no field moves without an effective tick. They also check that stop freezes the count, that the fields stay inside their legal ranges, and that the seconds-to-minutes and end-of-31-day-month wraps behave as required. Month-length selection, the February leap decision, the year-to-century carry and the weekday's lockstep with the date depend on long carry chains. Only the bench's scenarios show these: directed presets placed just before each boundary, and random ticks, stops and near-boundary sets compared against an integer calendar model.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter logic [7:0] RST_CEN = 8'h20,
  parameter logic [7:0] CEN_MAX = 8'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       stop,
  input  logic       set_en,
  input  logic [7:0] set_cen,
  input  logic [7:0] set_yr,
  input  logic [7:0] set_mon,
  input  logic [7:0] set_date,
  input  logic [7:0] set_wday,
  input  logic [7:0] set_hr,
  input  logic [7:0] set_min,
  input  logic [7:0] set_sec,
  output logic [7:0] cen,
  output logic [7:0] yr,
  output logic [7:0] mon,
  output logic [7:0] date,
  output logic [7:0] wday,
  output logic [7:0] hr,
  output logic [7:0] min,
  output logic [7:0] sec
);

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       leap;
  logic [7:0] last_day;

  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  wire adv   = sec_tick & ~stop;
  wire c_sec = adv   & (sec  >= 8'h59);
  wire c_min = c_sec & (min  >= 8'h59);
  wire c_hr  = c_min & (hr   >= 8'h23);
  wire c_dt  = c_hr  & (date >= last_day);
  wire c_mon = c_dt  & (mon  >= 8'h12);
  wire c_yr  = c_mon & (yr   >= 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hr   <= 8'h00;
      wday <= 8'h01;
      date <= 8'h01;
      mon  <= 8'h01;
      yr   <= 8'h00;
      cen  <= RST_CEN;
    end else if (set_en) begin
      sec  <= set_sec;
      min  <= set_min;
      hr   <= set_hr;
      wday <= set_wday;
      date <= set_date;
      mon  <= set_mon;
      yr   <= set_yr;
      cen  <= set_cen;
    end else begin
      if (adv)   sec <= c_sec ? 8'h00 : bcd_up(sec);
      if (c_sec) min <= c_min ? 8'h00 : bcd_up(min);
      if (c_min) hr  <= c_hr  ? 8'h00 : bcd_up(hr);
      if (c_hr) begin
        date <= c_dt ? 8'h01 : bcd_up(date);
        wday <= (wday >= 8'h07) ? 8'h01 : bcd_up(wday);
      end
      if (c_dt)  mon <= c_mon ? 8'h01 : bcd_up(mon);
      if (c_mon) yr  <= c_yr  ? 8'h00 : bcd_up(yr);
      if (c_yr)  cen <= (cen >= CEN_MAX) ? 8'h00 : bcd_up(cen);
    end
  end

endmodule

module bcd_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       stop,
  input logic       set_en,
  input logic [7:0] set_cen,
  input logic [7:0] set_yr,
  input logic [7:0] set_mon,
  input logic [7:0] set_date,
  input logic [7:0] set_wday,
  input logic [7:0] set_hr,
  input logic [7:0] set_min,
  input logic [7:0] set_sec,
  input logic [7:0] cen,
  input logic [7:0] yr,
  input logic [7:0] mon,
  input logic [7:0] date,
  input logic [7:0] wday,
  input logic [7:0] hr,
  input logic [7:0] min,
  input logic [7:0] sec
);

  wire [63:0] all_f = {cen, yr, mon, date, wday, hr, min, sec};
  wire [63:0] all_s = {set_cen, set_yr, set_mon, set_date, set_wday, set_hr, set_min, set_sec};

  // R8
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> all_f == $past(all_s));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !sec_tick) |=> $stable(all_f));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && stop) |=> $stable(all_f));

  // R2
  sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && sec_tick && !stop) |=> sec != $past(sec));

  // R2
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && sec_tick && !stop && sec == 8'h59 && min != 8'h59)
      |=> sec == 8'h00 && min != $past(min) && $stable(hr));

  // R3
  long_month_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && sec_tick && !stop && sec == 8'h59 && min == 8'h59 && hr == 8'h23 && date == 8'h31)
      |=> date == 8'h01);

  // R6
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wday >= 8'h01 && wday <= 8'h07);

  // R5
  mon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon >= 8'h01 && mon <= 8'h12);

endmodule

bind bcd_calendar_core bcd_calendar_core_chk chk_i (.*);

// File: tb/bcd_calendar_core_tb_top.sv
module bcd_calendar_core_tb_top;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic rst_n, sec_tick, stop, set_en;
  logic [7:0] set_cen, set_yr, set_mon, set_date, set_wday, set_hr, set_min, set_sec;
  logic [7:0] cen, yr, mon, date, wday, hr, min, sec;

  bcd_calendar_core dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int m_cen, m_yr, m_mon, m_date, m_wday, m_hr, m_min, m_sec;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0;
    m_cen = (m_cen == 39) ? 0 : m_cen + 1;
  endtask

  task automatic compare(input string req);
    logic [63:0] got, exp;
    got = {cen, yr, mon, date, wday, hr, min, sec};
    exp = {to_bcd(m_cen), to_bcd(m_yr), to_bcd(m_mon), to_bcd(m_date),
           to_bcd(m_wday), to_bcd(m_hr), to_bcd(m_min), to_bcd(m_sec)};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic t, input logic s, input logic ld, input string req);
    @(negedge clk);
    sec_tick = t; stop = s; set_en = ld;
    @(posedge clk);
    if (ld) begin
      m_cen = set_cen; m_yr = set_yr; m_mon = set_mon; m_date = set_date;
      m_wday = set_wday; m_hr = set_hr; m_min = set_min; m_sec = set_sec;
      m_cen = (m_cen >> 4) * 10 + (m_cen & 15); m_yr = (m_yr >> 4) * 10 + (m_yr & 15);
      m_mon = (m_mon >> 4) * 10 + (m_mon & 15); m_date = (m_date >> 4) * 10 + (m_date & 15);
      m_wday = m_wday & 15; m_hr = (m_hr >> 4) * 10 + (m_hr & 15);
      m_min = (m_min >> 4) * 10 + (m_min & 15); m_sec = (m_sec >> 4) * 10 + (m_sec & 15);
    end else if (t && !s) model_tick();
    @(negedge clk);
    sec_tick = 1'b0; set_en = 1'b0; stop = 1'b0;
    compare(req);
  endtask

  task automatic preset(input int c, input int y, input int mo, input int d,
                        input int w, input int h, input int mi, input int s);
    set_cen = to_bcd(c); set_yr = to_bcd(y); set_mon = to_bcd(mo); set_date = to_bcd(d);
    set_wday = to_bcd(w); set_hr = to_bcd(h); set_min = to_bcd(mi); set_sec = to_bcd(s);
    cycle(1'b0, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    #2ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_c10c);
    rst_n = 1'b0; sec_tick = 1'b0; stop = 1'b0; set_en = 1'b0;
    set_cen = 0; set_yr = 0; set_mon = 0; set_date = 0;
    set_wday = 0; set_hr = 0; set_min = 0; set_sec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_cen = 20; m_yr = 0; m_mon = 1; m_date = 1; m_wday = 1; m_hr = 0; m_min = 0; m_sec = 0;
    compare("R1");

    cycle(1'b1, 1'b0, 1'b0, "R2");
    cycle(1'b0, 1'b0, 1'b0, "R9");
    cycle(1'b1, 1'b1, 1'b0, "R7");

    // R3: 30-day month end
    preset(20, 21, 4, 30, 3, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R3");
    // R3: 31-day month end
    preset(20, 21, 7, 31, 7, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R3 R6");
    // R4: non-leap February
    preset(20, 3, 2, 28, 5, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R4");
    // R4: leap February 28 -> 29 -> Mar 1
    preset(20, 4, 2, 28, 5, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R4");
    set_hr = to_bcd(23); set_min = to_bcd(59); set_sec = to_bcd(59);
    preset(20, 4, 2, 29, 6, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R4");
    preset(20, 0, 2, 28, 1, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R4");
    // R5: year end and century roll
    preset(20, 99, 12, 31, 7, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R5");
    preset(39, 99, 12, 31, 2, 23, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R5");
    // R8: set beats tick in same cycle
    set_cen = 8'h19; set_yr = 8'h45; set_mon = 8'h06; set_date = 8'h15;
    set_wday = 8'h04; set_hr = 8'h12; set_min = 8'h34; set_sec = 8'h56;
    cycle(1'b1, 1'b0, 1'b1, "R8");
    // R7: stop across a full carry
    preset(20, 99, 12, 31, 7, 23, 59, 59);
    cycle(1'b1, 1'b1, 1'b0, "R7");
    // R2: hour roll
    preset(20, 10, 5, 10, 2, 9, 59, 59);
    cycle(1'b1, 1'b0, 1'b0, "R2");

    for (int i = 0; i < 6000; i++) begin
      logic t, s, ld;
      string tag;
      t  = ($urandom % 2) == 0;
      s  = ($urandom % 8) == 0;
      ld = ($urandom % 40) == 0;
      if (ld) begin
        int y, mo;
        y = $urandom % 100; mo = 1 + $urandom % 12;
        set_cen = to_bcd($urandom % 40); set_yr = to_bcd(y); set_mon = to_bcd(mo);
        set_date = to_bcd(($urandom % 2) ? days_in(mo, y) : 1 + $urandom % days_in(mo, y));
        set_wday = to_bcd(1 + $urandom % 7);
        set_hr = to_bcd(($urandom % 2) ? 23 : $urandom % 24);
        set_min = to_bcd(($urandom % 2) ? 59 : $urandom % 60);
        set_sec = to_bcd(50 + $urandom % 10);
      end
      tag = ld ? "R8" : s ? "R7" : !t ? "R9" : "R2 R3 R4 R5 R6";
      cycle(t, s, ld, tag);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule